// File: doc/BRIEF.md
# Framed SPI Write Receiver

This block is a receive-only serial slave front end for a converter that takes 32-bit register writes. The serial clock, serial data and active-low select pins are brought into the system clock domain through synchronizer chains. A frame opens on a falling edge of select. While the frame is open, each falling edge of the serial clock shifts one data bit into a shift register, most significant bit first. An edge counter tracks how far the frame has progressed.

When the 32nd falling edge arrives, the assembled word is placed on the output and a one-cycle update strobe is raised. If select rises before that point, the frame is thrown away and a one-cycle abort pulse is raised. If the host sends more clocks than needed, the shift register keeps moving. The last 32 bits are then committed with a second strobe when select rises. Serial clock activity while select is high is ignored. The receiver does not decode the command, address or data fields of the word. The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_frame_rx`

## Requirements
- R1: Bits are taken on serial clock falling edges inside an open frame, most significant bit first. After exactly 32 edges, the output word equals the 32 bits in arrival order, with the first bit at bit 31.
- R2: The update strobe for the 32nd falling edge is high for one system clock cycle. It is raised 3 system clock cycles after that edge reaches the pins, with the new word present in the same cycle.
- R3: If select rises after fewer than 32 falling edges, no strobe is produced and the output word keeps its previous value. A one-cycle abort pulse is raised 3 system clock cycles after select rises at the pin.
- R4: A frame with no serial clock edges at all also produces an abort pulse and no strobe.
- R5: If more than 32 falling edges arrive, the first strobe carries the first 32 bits. A second strobe, raised 3 cycles after select rises at the pin, carries the last 32 bits shifted in, and no abort pulse is raised.
- R6: Serial clock and data activity while select is high changes neither the word, the strobe nor the abort output. A later frame yields only its own bits.
- R7: A frame that follows an aborted frame starts from an empty shift register and a zero edge count.
- R8: A synchronous active-high reset clears the output word to zero and holds strobe and abort low. The block then waits for a select falling edge.
- R9: The edge counter saturates, so frames far longer than 32 edges, such as 100 edges, still commit the last 32 bits on select release.
- R10: A frame of exactly 32 edges produces exactly one strobe and no abort pulse when select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous; data taken on falling edges |
| sdi_i | input | 1 | Serial data pin, asynchronous |
| sel_n_i | input | 1 | Active-low frame select pin, asynchronous |
| word_o | output | WORD_W | Last committed word |
| word_stb_o | output | 1 | One-cycle pulse when word_o is updated |
| abort_o | output | 1 | One-cycle pulse when a frame ends short |

## Verification
The bench sweeps frame lengths from 0 to 40 edges and adds a 100-edge frame. It checks the strobe count, abort count, committed words and exact latencies against windows it computes from the bits it sent.

A wrong edge count shows up on the first frame of the affected length. It appears as a missing or extra strobe, or as a false abort, within 3 cycles of the 32nd edge or of select release. A shift register that is not cleared, or that shifts while the frame is closed, shows as a wrong word on the next full frame. A counter that wraps shows as a missing release strobe on the long frame.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;

  // saturating increment: stops at lim
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int            N       = 3,
  parameter int            STAGES  = 2,
  parameter logic [N-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= RST_VAL;
        else     stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= RST_VAL;
        else     stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl_i;
  end

  for (genvar b = 0; b < N; b++) begin : g_chg
    assign chg_o[b] = lvl_i[b] ^ prev_q[b];
  end

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_rx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CNT_MAX = WORD_W + 1,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en_i) begin
      shreg_q <= {shreg_q[WORD_W-2:0], din_i};
      cnt_q   <= CNT_W'(sat_inc(int'(cnt_q), CNT_MAX));
    end
  end

  assign shreg_o = shreg_q;
  assign cnt_o   = cnt_q;

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0 && shreg_q == '0));

  // R9
  count_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_TOP && shift_en_i && !clr_i) |=> cnt_q == CNT_TOP);

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sel_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_stb_o,
  output logic              abort_o
);

  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam int PIN_N = 3;
  // pin order in the synchronized vector: {select, data, clock}
  localparam logic [PIN_N-1:0] PIN_RST = 3'b101;

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] sr,
                                                 input logic b);
    return {sr[WORD_W-2:0], b};
  endfunction

  // ---------------- pin synchronization and edges ----------------
  logic [PIN_N-1:0] pin_raw, pin_s;
  assign pin_raw = {sel_n_i, sdi_i, sclk_i};

  spi_rx_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_raw),
    .q_o (pin_s)
  );

  logic [1:0] edge_lvl, edge_chg;
  assign edge_lvl = {pin_s[2], pin_s[0]};

  spi_rx_edge #(.N(2), .RST_VAL(2'b11)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (edge_lvl),
    .chg_o (edge_chg)
  );

  logic sclk_fall_w, sel_fall_w, sel_rise_w, sdi_w;
  assign sclk_fall_w = edge_chg[0] & ~edge_lvl[0];
  assign sel_fall_w  = edge_chg[1] & ~edge_lvl[1];
  assign sel_rise_w  = edge_chg[1] &  edge_lvl[1];
  assign sdi_w       = pin_s[1];

  // ---------------- frame control ----------------
  rx_state_e state_q;
  logic [WORD_W-1:0] shreg_w;
  logic [CNT_W-1:0]  cnt_w;

  logic open_w, release_w, shift_w, commit_w, surplus_w, short_w, clr_w;
  assign open_w    = (state_q == RX_IDLE)   && sel_fall_w;
  assign release_w = (state_q == RX_ACTIVE) && sel_rise_w;
  assign shift_w   = (state_q == RX_ACTIVE) && !sel_rise_w && sclk_fall_w;
  assign commit_w  = shift_w && (cnt_w == LAST_IDX);
  assign surplus_w = release_w && (cnt_w > FULL_CNT);
  assign short_w   = release_w && (cnt_w < FULL_CNT);
  assign clr_w     = open_w || release_w;

  spi_rx_shift #(.WORD_W(WORD_W), .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_w),
    .shift_en_i (shift_w),
    .din_i      (sdi_w),
    .shreg_o    (shreg_w),
    .cnt_o      (cnt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RX_IDLE;
      word_o     <= '0;
      word_stb_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      word_stb_o <= commit_w || surplus_w;
      abort_o    <= short_w;
      if (commit_w)       word_o <= push_bit(shreg_w, sdi_w);
      else if (surplus_w) word_o <= shreg_w;
      if (open_w)         state_q <= RX_ACTIVE;
      else if (release_w) state_q <= RX_IDLE;
    end
  end

  // R3
  stb_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(word_stb_o && abort_o));

  // R3
  abort_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(sel_rise_w && state_q == RX_ACTIVE));

  // R6
  stb_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |-> $past(state_q == RX_ACTIVE));

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_stb_o |-> $stable(word_o));

endmodule

// File: tb/tb_spi_frame_rx.sv
`timescale 1ns/1ps
module tb_spi_frame_rx;

  localparam int W = 32;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b1, sdi = 1'b0, sel_n = 1'b1;
  logic [W-1:0] word;
  logic stb, abrt;

  always #2.5 clk = ~clk;

  spi_frame_rx #(.WORD_W(W), .SYNC_STAGES(2)) dut (
    .clk        (clk),
    .rst        (rst),
    .sclk_i     (sclk),
    .sdi_i      (sdi),
    .sel_n_i    (sel_n),
    .word_o     (word),
    .word_stb_o (stb),
    .abort_o    (abrt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event monitor, sampled away from the active edge
  int n_stb = 0, n_ab = 0, stb_cyc = 0, prev_stb_cyc = 0, ab_cyc = 0;
  logic [W-1:0] stb_word = '0, prev_stb_word = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stb) begin
        n_stb         <= n_stb + 1;
        prev_stb_word <= stb_word;
        stb_word      <= word;
        prev_stb_cyc  <= stb_cyc;
        stb_cyc       <= cyc;
      end
      if (abrt) begin
        n_ab   <= n_ab + 1;
        ab_cyc <= cyc;
      end
    end
  end

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [127:0] dat;
  int fall32_cyc = 0, rise_cyc = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] window(input logic [127:0] d, input int last);
    logic [W-1:0] w = '0;
    for (int j = last - W; j < last; j++) w = {w[W-2:0], d[j]};
    return w;
  endfunction

  task automatic gen(input int seed);
    logic [31:0] s = 32'(seed);
    for (int k = 0; k < 128; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      dat[k] = s[31];
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bits(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = dat[i];
      tick(4);
      sclk = 1'b0;
      if (i == W - 1) fall32_cyc = cyc;
      tick(4);
      sclk = 1'b1;
    end
  endtask

  task automatic run_frame(input int n);
    int s0, a0;
    logic [W-1:0] w0;
    s0 = n_stb; a0 = n_ab; w0 = word;
    sel_n = 1'b0;
    tick(6);
    clock_bits(n);
    tick(4);
    sel_n = 1'b1;
    rise_cyc = cyc;
    tick(12);
    if (n < W) begin
      check($sformatf("R3 strobes n=%0d", n), 64'(n_stb - s0), 64'd0);
      check($sformatf("R3 aborts n=%0d", n), 64'(n_ab - a0), 64'd1);
      check($sformatf("R3 word held n=%0d", n), 64'(word), 64'(w0));
      check($sformatf("R3 abort latency n=%0d", n), 64'(ab_cyc), 64'(rise_cyc + 3));
      if (n == 0) check("R4 zero-edge frame aborts", 64'(n_ab - a0), 64'd1);
    end else if (n == W) begin
      check("R10 one strobe", 64'(n_stb - s0), 64'd1);
      check("R10 no abort", 64'(n_ab - a0), 64'd0);
      check("R1 word", 64'(word), 64'(window(dat, W)));
      check("R2 strobe latency", 64'(stb_cyc), 64'(fall32_cyc + 3));
    end else begin
      check($sformatf("R5 strobes n=%0d", n), 64'(n_stb - s0), 64'd2);
      check($sformatf("R5 no abort n=%0d", n), 64'(n_ab - a0), 64'd0);
      check($sformatf("R5 first word n=%0d", n), 64'(prev_stb_word), 64'(window(dat, W)));
      check($sformatf("R5 last word n=%0d", n), 64'(word), 64'(window(dat, n)));
      check($sformatf("R2 first strobe latency n=%0d", n), 64'(prev_stb_cyc), 64'(fall32_cyc + 3));
      check($sformatf("R5 release strobe latency n=%0d", n), 64'(stb_cyc), 64'(rise_cyc + 3));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int s0, a0;
    tick(4);
    // R8 reset state
    check("R8 reset word", 64'(word), 64'd0);
    check("R8 reset strobe/abort", 64'({stb, abrt}), 64'd0);
    rst = 1'b0;
    tick(5);

    // R6 clock activity with select high
    gen(99);
    s0 = n_stb; a0 = n_ab;
    clock_bits(40);
    tick(10);
    check("R6 no strobe while deselected", 64'(n_stb - s0), 64'd0);
    check("R6 no abort while deselected", 64'(n_ab - a0), 64'd0);
    check("R6 word untouched", 64'(word), 64'd0);
    gen(98);
    run_frame(W);
    check("R6 following frame holds only own bits", 64'(word), 64'(window(dat, W)));

    // sweep of frame lengths
    for (int n = 0; n <= 40; n++) begin
      gen(n + 1);
      run_frame(n);
    end

    // R7 frame after abort starts clean
    gen(500);
    run_frame(10);
    gen(501);
    run_frame(W);
    check("R7 clean frame after abort", 64'(word), 64'(window(dat, W)));

    // R9 long frame with saturating counter
    gen(7);
    run_frame(100);
    check("R9 long frame last bits", 64'(word), 64'(window(dat, 100)));

    // R8 reset in the middle of a frame
    gen(3);
    sel_n = 1'b0;
    tick(6);
    clock_bits(20);
    rst = 1'b1;
    tick(3);
    sel_n = 1'b1;
    tick(4);
    check("R8 reset clears word", 64'(word), 64'd0);
    rst = 1'b0;
    tick(6);
    s0 = n_stb; a0 = n_ab;
    tick(10);
    check("R8 idle after reset", 64'({32'(n_stb - s0), 32'(n_ab - a0)}), 64'd0);
    gen(4);
    run_frame(W);
    check("R8 frame after reset", 64'(word), 64'(window(dat, W)));

    done = 1'b1;
    summary();
  end

endmodule